// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

The block is a true dual-port synchronous RAM. Two ports, called left and right, each have an enable, a write strobe, an address, write data and registered read data. Both ports can reach every word at the same time. The two highest addresses can act as message slots between the ports. A port drops an interrupt toward its partner by writing the partner's slot. The partner releases the interrupt by reading that slot. The byte stored in a slot is ordinary user data.

A configuration input switches the slot behaviour on or off. When it is off, the two top words are plain storage and no interrupt moves. The address width is a parameter. The default is 10 bits (1K words) to keep elaboration small. With `ADDR_W = 14` the block is 16K x 8, and its slots sit at 0x3FFE and 0x3FFF. Collision arbitration and semaphores are not part of this block.

Top module: `dual_port_mailbox`

## Requirements
- R1: A write on an enabled port stores its data. An enabled read on the same port returns that data on its read-data output after the next rising clock edge (one cycle of latency).
- R2: A word written by one port is returned unchanged when the other port reads it.
- R3: While `rstN` is low, both interrupt outputs are high (inactive) and both read-data outputs are zero. Memory contents are not reset.
- R4: With `mboxEn` high, a right-port write to address 2^ADDR_W-2 (the left slot) drives `leftIntN` low from the next rising edge.
- R5: With `mboxEn` high, a left-port read (enable high, write strobe low) of the left slot returns `leftIntN` high from the next rising edge.
- R6: With `mboxEn` high, a left-port write to address 2^ADDR_W-1 (the right slot) drives `rightIntN` low from the next edge. A right-port read of that slot returns `rightIntN` high from the next edge.
- R7: A slot keeps the byte written to it and returns it on a read, like any other word.
- R8: With `mboxEn` low, accesses to the two top addresses store and return data normally, and neither interrupt output changes.
- R9: A port whose enable is low writes nothing, holds its read data, and neither sets nor clears any interrupt.
- R10: If a set and a clear of the same interrupt happen in the same cycle, the interrupt ends up active (low).
- R11: A port writing its own slot, or reading its partner's slot, leaves its own interrupt output unchanged.
- R12: Every enabled access, read or write, loads the port's read data with the word's content from before the edge (read-first). This also holds when the other port writes the same word in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| mboxEn | input | 1 | High turns the slot interrupts on |
| leftEn | input | 1 | Left port enable |
| leftWe | input | 1 | Left port write strobe (1 = write, 0 = read) |
| leftAddr | input | ADDR_W | Left port word address |
| leftWdata | input | DATA_W | Left port write data |
| leftRdata | output | DATA_W | Left port registered read data |
| leftIntN | output | 1 | Left interrupt, active low |
| rightEn | input | 1 | Right port enable |
| rightWe | input | 1 | Right port write strobe (1 = write, 0 = read) |
| rightAddr | input | ADDR_W | Right port word address |
| rightWdata | input | DATA_W | Right port write data |
| rightRdata | output | DATA_W | Right port registered read data |
| rightIntN | output | 1 | Right interrupt, active low |

## Verification
The bench sends a set and a clear of the same interrupt in one cycle, on both slots. A design where the clear wins would show an inactive interrupt when a message is actually waiting. It checks that a port writing its own slot, or reading its partner's slot, leaves its own flag alone; a loose address decode would set or drop that flag. With `mboxEn` low it sets up pending conditions and confirms that nothing moves. With the enable low it sets up a would-be set and a would-be clear, and checks that only enabled accesses act. Read-first data is checked on same-port and cross-port writes, and a mid-run reset must return both outputs to inactive.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;
  localparam int NUM_PORTS = 2;
  localparam int PORT_L    = 0;
  localparam int PORT_R    = 1;

  // strobes the control sends to the datapath, one bit per port
  typedef struct packed {
    logic [NUM_PORTS-1:0] acc;  // port performs an access this cycle
    logic [NUM_PORTS-1:0] wr;   // port writes this cycle
  } mem_strobe_t;
endpackage

// File: rtl/dpmb_ctrl.sv
module dpmb_ctrl
  import dpmb_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 mboxEn,
  input  logic [NUM_PORTS-1:0] en,
  input  logic [NUM_PORTS-1:0] we,
  input  logic [ADDR_W-1:0]    addr [NUM_PORTS],
  output mem_strobe_t          strb,
  output logic [NUM_PORTS-1:0] intN
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] SLOT_L   = TOP_ADDR - 1'b1;
  localparam logic [ADDR_W-1:0] SLOT_R   = TOP_ADDR;

  logic [NUM_PORTS-1:0] flagQ;
  logic [NUM_PORTS-1:0] setHit;
  logic [NUM_PORTS-1:0] clrHit;

  always_comb begin
    strb.acc = en;
    strb.wr  = en & we;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_flag
    localparam int                PARTNER = NUM_PORTS - 1 - p;
    localparam logic [ADDR_W-1:0] SLOT    = (p == PORT_L) ? SLOT_L : SLOT_R;

    // partner writes this port's slot -> raise
    assign setHit[p] = mboxEn && en[PARTNER] && we[PARTNER] && (addr[PARTNER] == SLOT);
    // this port reads its own slot -> release
    assign clrHit[p] = mboxEn && en[p] && !we[p] && (addr[p] == SLOT);

    always_ff @(posedge clk) begin
      if (!rstN)           flagQ[p] <= 1'b0;
      else if (setHit[p])  flagQ[p] <= 1'b1;  // set beats clear
      else if (clrHit[p])  flagQ[p] <= 1'b0;
    end
  end

  assign intN = ~flagQ;

  // R4
  p_set_left_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mboxEn && en[PORT_R] && we[PORT_R] && addr[PORT_R] == SLOT_L) |=> !intN[PORT_L]);

  // R5
  p_clear_left_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mboxEn && en[PORT_L] && !we[PORT_L] && addr[PORT_L] == SLOT_L &&
     !(en[PORT_R] && we[PORT_R] && addr[PORT_R] == SLOT_L)) |=> intN[PORT_L]);

  // R6
  p_set_right_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mboxEn && en[PORT_L] && we[PORT_L] && addr[PORT_L] == SLOT_R) |=> !intN[PORT_R]);

  // R8
  p_off_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    !mboxEn |=> ($stable(intN[PORT_L]) && $stable(intN[PORT_R])));

  // R9
  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    (en == '0) |=> $stable(intN));

  // R11
  p_own_slot_left_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!en[PORT_R] && en[PORT_L] && we[PORT_L]) |=> $stable(intN[PORT_L]));
endmodule

// File: rtl/dpmb_datapath.sv
module dpmb_datapath
  import dpmb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mem_strobe_t       strb,
  input  logic [ADDR_W-1:0] addr  [NUM_PORTS],
  input  logic [DATA_W-1:0] wdata [NUM_PORTS],
  output logic [DATA_W-1:0] rdata [NUM_PORTS]
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // single write process; the higher port index is applied last
  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (strb.wr[p]) mem[addr[p]] <= wdata[p];
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (!rstN)            rdata[p] <= '0;
      else if (strb.acc[p]) rdata[p] <= mem[addr[p]];  // read-first
    end

    // R9
    p_idle_port_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
      !strb.acc[p] |=> $stable(rdata[p]));
  end
endmodule

// File: rtl/dual_port_mailbox.sv
module dual_port_mailbox
  import dpmb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mboxEn,
  input  logic              leftEn,
  input  logic              leftWe,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic [DATA_W-1:0] leftWdata,
  output logic [DATA_W-1:0] leftRdata,
  output logic              leftIntN,
  input  logic              rightEn,
  input  logic              rightWe,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic [DATA_W-1:0] rightWdata,
  output logic [DATA_W-1:0] rightRdata,
  output logic              rightIntN
);
  logic [NUM_PORTS-1:0] enV;
  logic [NUM_PORTS-1:0] weV;
  logic [NUM_PORTS-1:0] intNV;
  logic [ADDR_W-1:0]    addrV  [NUM_PORTS];
  logic [DATA_W-1:0]    wdataV [NUM_PORTS];
  logic [DATA_W-1:0]    rdataV [NUM_PORTS];
  mem_strobe_t          strb;

  assign enV[PORT_L]    = leftEn;
  assign enV[PORT_R]    = rightEn;
  assign weV[PORT_L]    = leftWe;
  assign weV[PORT_R]    = rightWe;
  assign addrV[PORT_L]  = leftAddr;
  assign addrV[PORT_R]  = rightAddr;
  assign wdataV[PORT_L] = leftWdata;
  assign wdataV[PORT_R] = rightWdata;

  dpmb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .mboxEn(mboxEn),
    .en(enV), .we(weV), .addr(addrV),
    .strb(strb), .intN(intNV)
  );

  dpmb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .addr(addrV), .wdata(wdataV), .rdata(rdataV)
  );

  assign leftRdata  = rdataV[PORT_L];
  assign rightRdata = rdataV[PORT_R];
  assign leftIntN   = intNV[PORT_L];
  assign rightIntN  = intNV[PORT_R];
endmodule

// File: tb/dual_port_mailbox_tb.sv
module dual_port_mailbox_tb;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam logic [AW-1:0] SL = 10'd1022;  // left slot
  localparam logic [AW-1:0] SR = 10'd1023;  // right slot

  typedef struct packed {
    logic [7:0]    req;
    logic          enL; logic weL; logic [AW-1:0] aL; logic [DW-1:0] dL;
    logic          enR; logic weR; logic [AW-1:0] aR; logic [DW-1:0] dR;
    logic          mbox;
    logic          chkL; logic [DW-1:0] expL;
    logic          chkR; logic [DW-1:0] expR;
    logic          intL; logic intR;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{8'd1,  1'b1,1'b1,10'd5,8'hA5, 1'b0,1'b0,10'd0,8'h00, 1'b1, 1'b0,8'h00, 1'b0,8'h00, 1'b1,1'b1}, // R1
    '{8'd1,  1'b1,1'b0,10'd5,8'h00, 1'b1,1'b1,10'd7,8'h3C, 1'b1, 1'b1,8'hA5, 1'b0,8'h00, 1'b1,1'b1}, // R1
    '{8'd2,  1'b1,1'b0,10'd7,8'h00, 1'b1,1'b0,10'd5,8'h00, 1'b1, 1'b1,8'h3C, 1'b1,8'hA5, 1'b1,1'b1}, // R2
    '{8'd4,  1'b0,1'b0,10'd0,8'h00, 1'b1,1'b1,SL,   8'h5A, 1'b1, 1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b1}, // R4
    '{8'd11, 1'b1,1'b1,SL,   8'h11, 1'b0,1'b0,10'd0,8'h00, 1'b1, 1'b1,8'h5A, 1'b0,8'h00, 1'b0,1'b1}, // R11 R12
    '{8'd5,  1'b1,1'b0,SL,   8'h00, 1'b0,1'b0,10'd0,8'h00, 1'b1, 1'b1,8'h11, 1'b0,8'h00, 1'b1,1'b1}, // R5 R7
    '{8'd6,  1'b1,1'b1,SR,   8'h77, 1'b0,1'b0,10'd0,8'h00, 1'b1, 1'b0,8'h00, 1'b0,8'h00, 1'b1,1'b0}, // R6
    '{8'd11, 1'b0,1'b0,10'd0,8'h00, 1'b1,1'b1,SR,   8'h88, 1'b1, 1'b0,8'h00, 1'b1,8'h77, 1'b1,1'b0}, // R11
    '{8'd6,  1'b0,1'b0,10'd0,8'h00, 1'b1,1'b0,SR,   8'h00, 1'b1, 1'b0,8'h00, 1'b1,8'h88, 1'b1,1'b1}, // R6 R7
    '{8'd10, 1'b1,1'b1,SR,   8'h99, 1'b1,1'b0,SR,   8'h00, 1'b1, 1'b1,8'h88, 1'b1,8'h88, 1'b1,1'b0}, // R10
    '{8'd6,  1'b0,1'b0,10'd0,8'h00, 1'b1,1'b0,SR,   8'h00, 1'b1, 1'b0,8'h00, 1'b1,8'h99, 1'b1,1'b1}, // R6
    '{8'd8,  1'b0,1'b0,10'd0,8'h00, 1'b1,1'b1,SL,   8'hC3, 1'b0, 1'b0,8'h00, 1'b1,8'h11, 1'b1,1'b1}, // R8
    '{8'd8,  1'b1,1'b0,SL,   8'h00, 1'b0,1'b0,10'd0,8'h00, 1'b0, 1'b1,8'hC3, 1'b0,8'h00, 1'b1,1'b1}, // R8
    '{8'd4,  1'b0,1'b0,10'd0,8'h00, 1'b1,1'b1,SL,   8'hD4, 1'b1, 1'b0,8'h00, 1'b1,8'hC3, 1'b0,1'b1}, // R4
    '{8'd8,  1'b1,1'b0,SL,   8'h00, 1'b0,1'b0,10'd0,8'h00, 1'b0, 1'b1,8'hD4, 1'b0,8'h00, 1'b0,1'b1}, // R8
    '{8'd9,  1'b0,1'b0,SL,   8'h00, 1'b0,1'b0,10'd0,8'h00, 1'b1, 1'b1,8'hD4, 1'b0,8'h00, 1'b0,1'b1}, // R9
    '{8'd9,  1'b0,1'b0,10'd0,8'h00, 1'b0,1'b1,10'd5,8'hFF, 1'b1, 1'b1,8'hD4, 1'b1,8'hC3, 1'b0,1'b1}, // R9
    '{8'd9,  1'b1,1'b0,10'd5,8'h00, 1'b0,1'b0,10'd0,8'h00, 1'b1, 1'b1,8'hA5, 1'b1,8'hC3, 1'b0,1'b1}, // R9
    '{8'd9,  1'b1,1'b0,SL,   8'h00, 1'b0,1'b1,SL,   8'hEE, 1'b1, 1'b1,8'hD4, 1'b1,8'hC3, 1'b1,1'b1}, // R9
    '{8'd10, 1'b1,1'b0,SL,   8'h00, 1'b1,1'b1,SL,   8'hE1, 1'b1, 1'b1,8'hD4, 1'b1,8'hD4, 1'b0,1'b1}, // R10
    '{8'd5,  1'b1,1'b0,SL,   8'h00, 1'b0,1'b0,10'd0,8'h00, 1'b1, 1'b1,8'hE1, 1'b1,8'hD4, 1'b1,1'b1}, // R5
    '{8'd12, 1'b1,1'b1,10'd5,8'h6B, 1'b1,1'b0,10'd5,8'h00, 1'b1, 1'b1,8'hA5, 1'b1,8'hA5, 1'b1,1'b1}, // R12
    '{8'd12, 1'b0,1'b0,10'd0,8'h00, 1'b1,1'b0,10'd5,8'h00, 1'b1, 1'b1,8'hA5, 1'b1,8'h6B, 1'b1,1'b1}  // R12
  };

  logic clk = 1'b0;
  logic rstN;
  logic mboxEn;
  logic leftEn, leftWe, rightEn, rightWe;
  logic [AW-1:0] leftAddr, rightAddr;
  logic [DW-1:0] leftWdata, rightWdata, leftRdata, rightRdata;
  logic leftIntN, rightIntN;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  dual_port_mailbox #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .mboxEn(mboxEn),
    .leftEn(leftEn), .leftWe(leftWe), .leftAddr(leftAddr),
    .leftWdata(leftWdata), .leftRdata(leftRdata), .leftIntN(leftIntN),
    .rightEn(rightEn), .rightWe(rightWe), .rightAddr(rightAddr),
    .rightWdata(rightWdata), .rightRdata(rightRdata), .rightIntN(rightIntN)
  );

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    leftEn = 0; leftWe = 0; leftAddr = '0; leftWdata = '0;
    rightEn = 0; rightWe = 0; rightAddr = '0; rightWdata = '0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    summary();
  end

  initial begin
    idle();
    mboxEn = 1'b1;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R3: reset state
    check("R3", "leftIntN",   {7'b0, leftIntN},  8'h01);
    check("R3", "rightIntN",  {7'b0, rightIntN}, 8'h01);
    check("R3", "leftRdata",  leftRdata,  8'h00);
    check("R3", "rightRdata", rightRdata, 8'h00);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = VECS[i];
      tag = $sformatf("R%0d(vec %0d)", v.req, i);
      leftEn = v.enL; leftWe = v.weL; leftAddr = v.aL; leftWdata = v.dL;
      rightEn = v.enR; rightWe = v.weR; rightAddr = v.aR; rightWdata = v.dR;
      mboxEn = v.mbox;
      @(negedge clk);
      check(tag, "leftIntN",  {7'b0, leftIntN},  {7'b0, v.intL});
      check(tag, "rightIntN", {7'b0, rightIntN}, {7'b0, v.intR});
      if (v.chkL) check(tag, "leftRdata",  leftRdata,  v.expL);
      if (v.chkR) check(tag, "rightRdata", rightRdata, v.expR);
    end

    // R3: reset in mid-run returns pending interrupts to inactive
    idle(); mboxEn = 1'b1;
    leftEn = 1; leftWe = 1; leftAddr = SR; leftWdata = 8'h42;
    rightEn = 1; rightWe = 1; rightAddr = SL; rightWdata = 8'h24;
    @(negedge clk);
    check("R4", "leftIntN before reset",  {7'b0, leftIntN},  8'h00);
    check("R6", "rightIntN before reset", {7'b0, rightIntN}, 8'h00);
    idle();
    rstN = 1'b0;
    @(negedge clk);
    check("R3", "leftIntN in reset",   {7'b0, leftIntN},  8'h01);
    check("R3", "rightIntN in reset",  {7'b0, rightIntN}, 8'h01);
    check("R3", "leftRdata in reset",  leftRdata,  8'h00);
    check("R3", "rightRdata in reset", rightRdata, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    // R7: slot contents survive reset
    leftEn = 1; leftAddr = SR; rightEn = 1; rightAddr = SL;
    mboxEn = 1'b0;
    @(negedge clk);
    check("R7", "leftRdata right slot", leftRdata,  8'h42);
    check("R7", "rightRdata left slot", rightRdata, 8'h24);
    idle();
    @(negedge clk);
    summary();
  end
endmodule